// File: doc/BRIEF.md
# Dual Down-Counting Timer

This block is a register-mapped peripheral that holds two independent down-counters, each 32 bits wide by default. Each counter has an enable bit, an auto-reload bit, a reload register and a live count register. While a counter is enabled it counts down by one on every clock. When it sits at zero on an enabled clock it has expired. In reload mode it then takes the reload value and keeps running. In one-shot mode it parks at zero and reports the expiry only once.

The usual setup runs timer 0 freely as a time base. Its count and reload registers are both loaded with all ones and reload is enabled. Software reads elapsed clocks as all-ones minus the live count. Timer 1 serves as a tick source, either periodic with reload or one-shot. A one-shot is armed by writing the delay to the count register and then setting the enable bit with reload cleared. Each expiry sets a sticky cause bit. Mask bits gate the cause bits onto a single interrupt line.

Software reaches every register through a single-cycle bus: byte address, write strobe, write data and combinational read data.

Top module: `dual_down_timer`

## Requirements
- R1: After reset, every register reads zero, both counters are stopped and `irq` is low.
- R2: An enabled counter that is non-zero and not being written drops by exactly one per clock. A disabled counter holds its value. Timer 0 loaded with 0xFFFFFFFF reads 0xFFFFFFFF-k after k enabled clocks.
- R3: With reload enabled, an enabled counter at zero takes its reload value on that clock. The period is therefore reload+1 clocks, and every expiry sets the timer's cause bit.
- R4: With reload disabled, an enabled counter stays at zero and its enable bit stays set. It sets its cause bit only once per arming, V+1 clocks after the enable write when V was loaded. Writing the count register re-arms it.
- R5: A write to a count register takes effect on that clock, even while the counter runs. It overrides the decrement and any expiry on that clock.
- R6: The register map is as follows. Control is at 0x00, with bit0 = timer 0 enable, bit1 = timer 0 reload, bit2 = timer 1 enable and bit3 = timer 1 reload. Timer 0 reload is at 0x10 and timer 0 count at 0x14. Timer 1 reload is at 0x18 and timer 1 count at 0x1C. Cause is at 0x20 and mask at 0x24. Unused bits and unmapped addresses read zero.
- R7: Cause bit1 records a timer 0 expiry and bit2 a timer 1 expiry. Both are sticky. A cause write clears the bits written 0 and leaves the bits written 1. An expiry on the same clock as a clear leaves the bit set.
- R8: The mask uses the same bit positions as cause, and only bits 1 and 2 are stored. `irq` is high exactly when some cause bit has its mask bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; also the counting tick |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W (6) | Byte address of the register |
| reg_wr | input | 1 | Write strobe, one clock per write |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Read data for `reg_addr`, combinational |
| irq | output | 1 | OR of cause bits enabled by mask |

## Verification
Some rules are checked by assertions on every cycle. These are the single-step decrement, holding while disabled, the reload step at zero, parking at zero in one-shot mode, immediate loads of the count register, that cause bits never drop without a cause write, and that `irq` stays low with an empty mask. Other behaviour only the bench scenarios can show. Those scenarios sweep reload values to show the reload+1 period and sweep one-shot delays to show that the expiry lands exactly V+1 clocks after enabling and fires once. They also cover the race between a cause clear and a new expiry, and the register map with its zero-reading unused bits.

// File: rtl/dual_down_timer.sv
module dual_down_timer #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] A_CAUSE = ADDR_W'('h20);
  localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'('h24);

  logic [3:0] ctrl;
  logic [2:1] cause, mask;
  logic [1:0] expire;
  logic [1:0][DATA_W-1:0] cnt_q, rld_q;

  wire wr_ctrl  = reg_wr && reg_addr == A_CTRL;
  wire wr_cause = reg_wr && reg_addr == A_CAUSE;
  wire wr_mask  = reg_wr && reg_addr == A_MASK;

  for (genvar g = 0; g < 2; g++) begin : g_tmr
    localparam logic [ADDR_W-1:0] A_RLD = ADDR_W'('h10 + 8 * g);
    localparam logic [ADDR_W-1:0] A_VAL = ADDR_W'('h14 + 8 * g);
    logic [DATA_W-1:0] cnt, rld;
    logic done;
    wire run   = ctrl[2*g];
    wire auto  = ctrl[2*g+1];
    wire wr_v  = reg_wr && reg_addr == A_VAL;
    wire wr_r  = reg_wr && reg_addr == A_RLD;
    wire at0   = cnt == '0;

    assign expire[g] = run && at0 && !wr_v && (auto || !done);
    assign cnt_q[g]  = cnt;
    assign rld_q[g]  = rld;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt  <= '0;
        rld  <= '0;
        done <= 1'b0;
      end else begin
        if (wr_r) rld <= reg_wdata;
        if (wr_v) begin
          cnt  <= reg_wdata;
          done <= 1'b0;
        end else if (run) begin
          if (at0) begin
            if (auto) cnt <= rld;
            done <= !auto;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl  <= '0;
      cause <= '0;
      mask  <= '0;
    end else begin
      if (wr_ctrl) ctrl <= reg_wdata[3:0];
      if (wr_mask) mask <= reg_wdata[2:1];
      cause <= (wr_cause ? (cause & reg_wdata[2:1]) : cause) | expire;
    end
  end

  assign irq = |(cause & mask);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:           reg_rdata[3:0] = ctrl;
      ADDR_W'('h10):    reg_rdata = rld_q[0];
      ADDR_W'('h14):    reg_rdata = cnt_q[0];
      ADDR_W'('h18):    reg_rdata = rld_q[1];
      ADDR_W'('h1C):    reg_rdata = cnt_q[1];
      A_CAUSE:          reg_rdata[2:1] = cause;
      A_MASK:           reg_rdata[2:1] = mask;
      default:          reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dual_down_timer_chk.sv
module dual_down_timer_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [3:0]        ctrl,
  input logic [DATA_W-1:0] cnt0,
  input logic [DATA_W-1:0] cnt1,
  input logic [DATA_W-1:0] rld1,
  input logic [2:1]        cause,
  input logic [2:1]        mask,
  input logic              irq
);
  wire wv0 = reg_wr && reg_addr == ADDR_W'('h14);
  wire wv1 = reg_wr && reg_addr == ADDR_W'('h1C);
  wire wct = reg_wr && reg_addr == ADDR_W'('h00);
  wire wca = reg_wr && reg_addr == ADDR_W'('h20);

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[0] && !wv0) |=> $stable(cnt0)); // R2
  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[0] && cnt0 != '0 && !wv0) |=> cnt0 == $past(cnt0) - 1'b1); // R2
  AST_RELOAD_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[2] && ctrl[3] && cnt1 == '0 && !wv1) |=> cnt1 == $past(rld1)); // R3
  AST_ONESHOT_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[2] && !ctrl[3] && cnt1 == '0 && !wv1 && !wct) |=> (cnt1 == '0 && ctrl[2])); // R4
  AST_LOAD_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    wv1 |=> cnt1 == $past(reg_wdata)); // R5
  AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !wca |=> ($past(cause) & ~cause) == 2'b00); // R7
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == 2'b00) |-> !irq); // R8
endmodule

bind dual_down_timer dual_down_timer_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .ctrl(ctrl), .cnt0(cnt_q[0]), .cnt1(cnt_q[1]),
  .rld1(rld_q[1]), .cause(cause), .mask(mask), .irq(irq)
);

// File: tb/sim_dual_down_timer.sv
`timescale 1ns/1ps
module sim_dual_down_timer;
  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0, irq;
  logic [5:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  dual_down_timer u0 (.clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d, e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    foreach (u0.reg_rdata[i]) if (i < 10) begin
      rd(6'(i * 4), d);
      check("R1 reg read", d, 0);
    end
    check("R1 irq", {31'd0, irq}, 0);

    // R6 map and unused bits
    wr(6'h00, 32'hFFFF_FFF0); rd(6'h00, d); check("R6 ctrl unused", d, 0);
    wr(6'h24, 32'hFFFF_FFFF); rd(6'h24, d); check("R6 mask bits", d, 32'h6);
    wr(6'h24, 0);
    wr(6'h10, 32'h1234_5678); rd(6'h10, d); check("R6 reload0", d, 32'h1234_5678);
    wr(6'h18, 32'h0BAD_F00D); rd(6'h18, d); check("R6 reload1", d, 32'h0BAD_F00D);
    rd(6'h2C, d); check("R6 unmapped", d, 0);

    // R2 free-running time base
    wr(6'h14, 32'hFFFF_FFFF); wr(6'h10, 32'hFFFF_FFFF); wr(6'h00, 32'h3);
    repeat (10) @(negedge clk);
    rd(6'h14, d); check("R2 elapsed", ~d, 10);
    wr(6'h00, 0);
    rd(6'h14, e); repeat (5) @(negedge clk); rd(6'h14, d); check("R2 hold when off", d, e);

    // R5 live load while running
    wr(6'h00, 32'h3);
    wr(6'h14, 100); rd(6'h14, d); check("R5 load now", d, 100);
    @(negedge clk); rd(6'h14, d); check("R5 then count", d, 99);
    wr(6'h00, 0);

    // R3 periodic sweep on timer 1
    for (int r = 0; r < 6; r++) begin
      wr(6'h00, 0); wr(6'h20, 0);
      wr(6'h18, r); wr(6'h1C, r); wr(6'h00, 32'hC);
      e = r;
      for (int k = 0; k < 3 * (r + 1) + 2; k++) begin
        @(negedge clk);
        e = (e == 0) ? 32'(r) : e - 1;
        rd(6'h1C, d); check("R3 periodic value", d, e);
      end
      rd(6'h20, d); check("R3 cause set", d & 32'h4, 32'h4);
    end

    // R4 one-shot sweep on timer 1
    for (int v = 0; v < 7; v++) begin
      int first;
      wr(6'h00, 0); wr(6'h20, 0); wr(6'h1C, v); wr(6'h00, 32'h4);
      first = -1;
      for (int k = 1; k < 12 && first < 0; k++) begin
        @(negedge clk); rd(6'h20, d);
        if (d[2]) first = k;
      end
      check("R4 one-shot delay", first, v + 1);
      wr(6'h20, 0);
      repeat (4) @(negedge clk);
      rd(6'h20, d); check("R4 fires once", d, 0);
      rd(6'h1C, d); check("R4 parks at zero", d, 0);
      rd(6'h00, d); check("R4 enable kept", d, 32'h4);
    end
    wr(6'h1C, 2); repeat (4) @(negedge clk);
    rd(6'h20, d); check("R4 rearm by value write", d, 32'h4);

    // R8 masking
    wr(6'h00, 0);
    check("R8 mask empty", {31'd0, irq}, 0);
    wr(6'h24, 32'h4); check("R8 mask hit", {31'd0, irq}, 1);
    wr(6'h24, 32'h2); check("R8 mask miss", {31'd0, irq}, 0);

    // R7 selective clear and race with expiry
    wr(6'h10, 0); wr(6'h14, 0); wr(6'h00, 32'h3);
    wr(6'h00, 0);
    rd(6'h20, d); check("R7 both set", d, 32'h6);
    wr(6'h20, 32'h4); rd(6'h20, d); check("R7 keep written 1", d, 32'h4);
    wr(6'h00, 32'h3);
    wr(6'h20, 0); rd(6'h20, d); check("R7 expiry beats clear", d, 32'h2);
    check("R8 irq from bit1", {31'd0, irq}, 1);
    wr(6'h00, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule